// File: doc/BRIEF.md
# E1 Timing Event and Transmit Clock Loss Monitor

This block produces the periodic status events that an E1 framer reports to its host. The receive and transmit framing logic supply one-cycle boundary strobes for align frames and multiframes. Each strobe counts only on a cycle where the matching bit-clock enable is high. A bit-clock timer counts receive bit enables and raises a timer event once per second. With the fast select set, it raises the event every 62.5 ms instead. Each event sets a sticky status bit, and the bit stays set until the host pulses the clear strobe for it.

A second function watches the sampled transmit clock. The clock is resynchronised through two flops into the system clock domain, and its edges are detected there. If no edge of either polarity arrives for one 8-bit channel time (about 3.9 µs), the block sets a loss status bit. It also drives a fault pin, but only when the pin enable is high. The fault condition ends on the first transmit clock edge detected after the fault, and the pin then drops. The sticky status bit stays set until it is cleared.

All inputs and outputs are plain control and status signals with no handshake. Status bit order: bit 0 receive multiframe, bit 1 receive align frame, bit 2 transmit multiframe, bit 3 transmit align frame, bit 4 timer, bit 5 transmit clock loss.

Top module: `e1_event_monitor`

## Requirements
- R1: A cycle with `rx_mf_start` and `rx_bit_en` both high sets `status[0]` at the next clock edge. A strobe without the enable has no effect.
- R2: A cycle with `rx_align` and `rx_bit_en` both high sets `status[1]` at the next clock edge. A strobe without the enable has no effect.
- R3: A cycle with `tx_mf_start` and `tx_bit_en` both high sets `status[2]` at the next clock edge. The receive enable does not qualify it.
- R4: A cycle with `tx_align` and `tx_bit_en` both high sets `status[3]` at the next clock edge.
- R5: `status[4]` is set on the SLOW_COUNT-th `rx_bit_en` after reset or after the previous timer event when `fast_timer` is 0. When `fast_timer` is 1, it is set on the FAST_COUNT-th. Cycles without `rx_bit_en` do not advance the timer.
- R6: Each status bit stays set until its `clr_stb` bit is pulsed. A clear clears only its own bit. If a set and a clear for the same bit arrive in the same cycle, the bit stays set.
- R7: When no transmit clock edge is detected for LOSS_CYCLES system clocks, `status[5]` is set and the loss condition becomes active. LOSS_CYCLES equals SYS_CLK_MHZ*3906/1000. While the clock keeps toggling, the condition never becomes active.
- R8: `clkloss_pin` is high only while the loss condition is active and `clkloss_pin_en` is 1. The enable does not affect `status[5]`.
- R9: The first transmit clock edge after a fault ends the loss condition, and `clkloss_pin` falls within four system clocks of the input toggle. `status[5]` stays set until it is cleared.
- R10: After reset all status bits and `clkloss_pin` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit_en | input | 1 | Receive bit-clock enable |
| rx_align | input | 1 | Start of receive align frame |
| rx_mf_start | input | 1 | Receive multiframe boundary |
| tx_bit_en | input | 1 | Transmit bit-clock enable |
| tx_align | input | 1 | Start of transmit align frame |
| tx_mf_start | input | 1 | Transmit multiframe boundary |
| fast_timer | input | 1 | 1 selects the 62.5 ms timer period |
| tx_clk_smp | input | 1 | Asynchronous sampled transmit clock |
| clkloss_pin_en | input | 1 | Enables the fault pin |
| clr_stb | input | 6 | Per-bit clear strobe for the status bits |
| status | output | 6 | Sticky event status |
| clkloss_pin | output | 1 | Transmit clock loss fault pin |

## Verification
Each boundary event and each timer event appears on `status` one clock after its qualified input cycle. The bench drives inputs just after a falling edge and samples at the following falling edge, one rising edge later. The loss pin is due LOSS_CYCLES plus three clocks after the last input toggle, so it is checked with wide margins on both sides of that point. Recovery passes through the two synchroniser flops and one edge-detect flop, so the pin is checked low five clocks after the restart toggle has had time to occur.

// File: rtl/e1_evt_pkg.sv
package e1_evt_pkg;
  localparam int EVT_W = 6;
  typedef enum int unsigned {
    EV_RXMF  = 0,
    EV_RXAF  = 1,
    EV_TXMF  = 2,
    EV_TXAF  = 3,
    EV_TICK  = 4,
    EV_TXCKL = 5
  } evt_idx_e;
endpackage

// File: rtl/e1_bitclk_timer.sv
module e1_bitclk_timer #(
  parameter int unsigned SLOW_COUNT = 2048000,
  parameter int unsigned FAST_COUNT = 128000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic fast_sel,
  output logic tick
);
  localparam int CW = $clog2(SLOW_COUNT + 1);
  localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_COUNT - 1);
  localparam logic [CW-1:0] FAST_LAST = CW'(FAST_COUNT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = fast_sel ? FAST_LAST : SLOW_LAST;
  // >= covers a switch to the shorter period while the count is already past it
  assign tick = bit_en && (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (bit_en) cnt_q <= tick ? '0 : cnt_q + 1'b1;
  end

  AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick); // R5
endmodule

// File: rtl/e1_txclk_watchdog.sv
module e1_txclk_watchdog #(
  parameter int unsigned SYS_CLK_MHZ = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txclk_async,
  output logic loss_evt,
  output logic loss_active
);
  localparam int unsigned LOSS_CYCLES = (SYS_CLK_MHZ * 3906) / 1000;
  localparam int CW = $clog2(LOSS_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(LOSS_CYCLES);

  logic [2:0] sync_q;
  logic       edge_det;
  logic [CW-1:0] quiet_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else sync_q <= {sync_q[1:0], txclk_async};
  end

  assign edge_det = sync_q[2] ^ sync_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) quiet_q <= '0;
    else if (edge_det) quiet_q <= '0;
    else if (quiet_q != LIM) quiet_q <= quiet_q + 1'b1;
  end

  assign loss_active = (quiet_q == LIM);
  assign loss_evt    = !edge_det && (quiet_q == LIM - 1'b1);

  AST_EDGE_ENDS_LOSS: assert property (@(posedge clk) disable iff (!rst_n) edge_det |=> !loss_active); // R9
  AST_LOSS_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $rose(loss_active) |-> $past(!edge_det)); // R7
endmodule

// File: rtl/e1_sticky_status.sv
module e1_sticky_status #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] stat
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) stat[i] <= 1'b0;
      else if (set_vec[i]) stat[i] <= 1'b1;
      else if (clr_vec[i]) stat[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) set_vec[i] |=> stat[i]); // R6
    AST_CLR_OWN_BIT: assert property (@(posedge clk) disable iff (!rst_n) (clr_vec[i] && !set_vec[i]) |=> !stat[i]); // R6
  end
endmodule

// File: rtl/e1_event_monitor.sv
module e1_event_monitor
  import e1_evt_pkg::*;
#(
  parameter int unsigned SLOW_COUNT  = 2048000,
  parameter int unsigned FAST_COUNT  = 128000,
  parameter int unsigned SYS_CLK_MHZ = 125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit_en,
  input  logic             rx_align,
  input  logic             rx_mf_start,
  input  logic             tx_bit_en,
  input  logic             tx_align,
  input  logic             tx_mf_start,
  input  logic             fast_timer,
  input  logic             tx_clk_smp,
  input  logic             clkloss_pin_en,
  input  logic [EVT_W-1:0] clr_stb,
  output logic [EVT_W-1:0] status,
  output logic             clkloss_pin
);
  logic tick;
  logic loss_evt;
  logic loss_active;
  logic [EVT_W-1:0] set_vec;

  e1_bitclk_timer #(.SLOW_COUNT(SLOW_COUNT), .FAST_COUNT(FAST_COUNT)) u_timer (
    .clk(clk), .rst_n(rst_n), .bit_en(rx_bit_en), .fast_sel(fast_timer), .tick(tick)
  );

  e1_txclk_watchdog #(.SYS_CLK_MHZ(SYS_CLK_MHZ)) u_wdog (
    .clk(clk), .rst_n(rst_n), .txclk_async(tx_clk_smp),
    .loss_evt(loss_evt), .loss_active(loss_active)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[EV_RXMF]  = rx_bit_en && rx_mf_start;
    set_vec[EV_RXAF]  = rx_bit_en && rx_align;
    set_vec[EV_TXMF]  = tx_bit_en && tx_mf_start;
    set_vec[EV_TXAF]  = tx_bit_en && tx_align;
    set_vec[EV_TICK]  = tick;
    set_vec[EV_TXCKL] = loss_evt;
  end

  e1_sticky_status #(.W(EVT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_stb), .stat(status)
  );

  assign clkloss_pin = loss_active && clkloss_pin_en;

  AST_PIN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) clkloss_pin |-> clkloss_pin_en); // R8
  AST_TICK_FROM_BITCLK: assert property (@(posedge clk) disable iff (!rst_n) $rose(status[EV_TICK]) |-> $past(rx_bit_en)); // R5
  AST_RXMF_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n) $rose(status[EV_RXMF]) |-> $past(rx_bit_en && rx_mf_start)); // R1
  AST_TXAF_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n) $rose(status[EV_TXAF]) |-> $past(tx_bit_en && tx_align)); // R4
endmodule

// File: tb/test_e1_event_monitor.sv
module test_e1_event_monitor;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic rx_bit_en = 0, rx_align = 0, rx_mf_start = 0;
  logic tx_bit_en = 0, tx_align = 0, tx_mf_start = 0;
  logic fast_timer = 0, tx_clk_smp = 0, clkloss_pin_en = 1;
  logic [5:0] clr_stb = '0;
  logic [5:0] status;
  logic clkloss_pin;
  logic txck_run = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;

  e1_event_monitor #(.SLOW_COUNT(40), .FAST_COUNT(10), .SYS_CLK_MHZ(8)) i_e1_event_monitor (
    .clk(clk), .rst_n(rst_n), .rx_bit_en(rx_bit_en), .rx_align(rx_align),
    .rx_mf_start(rx_mf_start), .tx_bit_en(tx_bit_en), .tx_align(tx_align),
    .tx_mf_start(tx_mf_start), .fast_timer(fast_timer), .tx_clk_smp(tx_clk_smp),
    .clkloss_pin_en(clkloss_pin_en), .clr_stb(clr_stb), .status(status),
    .clkloss_pin(clkloss_pin)
  );

  // fields: [13:10] strobes {txaf,txmf,rxaf,rxmf}, [9:8] {tx_en,rx_en}, [7:4] clear, [3:0] expected status[3:0]
  localparam logic [13:0] VEC [12] = '{
    {4'b0001, 2'b01, 4'b0000, 4'b0001},
    {4'b0010, 2'b00, 4'b0000, 4'b0001},
    {4'b0010, 2'b01, 4'b0000, 4'b0011},
    {4'b0100, 2'b01, 4'b0000, 4'b0011},
    {4'b0100, 2'b10, 4'b0000, 4'b0111},
    {4'b1000, 2'b10, 4'b0000, 4'b1111},
    {4'b0000, 2'b11, 4'b0001, 4'b1110},
    {4'b0010, 2'b01, 4'b0010, 4'b1110},
    {4'b0000, 2'b00, 4'b1111, 4'b0000},
    {4'b1100, 2'b10, 4'b0000, 4'b1100},
    {4'b0000, 2'b00, 4'b0100, 4'b1000},
    {4'b0000, 2'b00, 4'b1000, 4'b0000}
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rx_pulses(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); rx_bit_en = 1'b1;
      @(negedge clk); rx_bit_en = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    idle(3); rst_n = 1'b1;
  endtask

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      if (txck_run) begin
        div++;
        if (div == 4) begin div = 0; tx_clk_smp = ~tx_clk_smp; end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1'b1;
    idle(1);
    chk({2'b0, status}, 8'h00, "R10 status after reset");
    chk({7'b0, clkloss_pin}, 8'h00, "R10 pin after reset");

    // vector walk: R1 R2 R3 R4 R6
    for (int v = 0; v < 12; v++) begin
      @(negedge clk);
      {tx_align, tx_mf_start, rx_align, rx_mf_start} = VEC[v][13:10];
      {tx_bit_en, rx_bit_en} = VEC[v][9:8];
      clr_stb = {2'b00, VEC[v][7:4]};
      @(negedge clk);
      chk({4'b0, status[3:0]}, {4'b0, VEC[v][3:0]}, $sformatf("R1 R2 R3 R4 R6 vector %0d", v));
      {tx_align, tx_mf_start, rx_align, rx_mf_start} = '0;
      {tx_bit_en, rx_bit_en} = '0;
      clr_stb = '0;
    end

    // R5 timer, fresh count
    do_reset();
    chk({2'b0, status}, 8'h00, "R10 status after second reset");
    fast_timer = 1'b1;
    rx_pulses(9);
    idle(20);
    chk({7'b0, status[4]}, 8'h00, "R5 fast timer before 10th enable");
    rx_pulses(1);
    chk({7'b0, status[4]}, 8'h01, "R5 fast timer on 10th enable");
    @(negedge clk); clr_stb = 6'b010000;
    @(negedge clk); clr_stb = '0;
    chk({7'b0, status[4]}, 8'h00, "R6 timer bit cleared");
    fast_timer = 1'b0;
    rx_pulses(39);
    chk({7'b0, status[4]}, 8'h00, "R5 slow timer before 40th enable");
    rx_pulses(1);
    chk({7'b0, status[4]}, 8'h01, "R5 slow timer on 40th enable");

    // R7 R8 R9 transmit clock watchdog (LOSS_CYCLES = 31)
    idle(60);
    chk({7'b0, status[5]}, 8'h00, "R7 no loss while toggling");
    chk({7'b0, clkloss_pin}, 8'h00, "R7 pin low while toggling");
    txck_run = 1'b0;
    idle(20);
    chk({7'b0, clkloss_pin}, 8'h00, "R7 pin low before timeout");
    idle(25);
    chk({7'b0, clkloss_pin}, 8'h01, "R7 pin high after timeout");
    chk({7'b0, status[5]}, 8'h01, "R7 loss status set");
    clkloss_pin_en = 1'b0;
    @(negedge clk);
    chk({7'b0, clkloss_pin}, 8'h00, "R8 pin gated by enable");
    chk({7'b0, status[5]}, 8'h01, "R8 status kept with enable low");
    clkloss_pin_en = 1'b1;
    @(negedge clk);
    chk({7'b0, clkloss_pin}, 8'h01, "R8 pin returns with enable");
    @(negedge clk); tx_clk_smp = ~tx_clk_smp;
    idle(5);
    chk({7'b0, clkloss_pin}, 8'h00, "R9 pin falls after edge");
    chk({7'b0, status[5]}, 8'h01, "R9 status stays sticky");
    txck_run = 1'b1;
    @(negedge clk); clr_stb = 6'b100000;
    @(negedge clk); clr_stb = '0;
    chk({7'b0, status[5]}, 8'h00, "R6 loss bit cleared");
    idle(40);
    chk({7'b0, clkloss_pin}, 8'h00, "R7 no relapse while toggling");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule